// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits next to a small 32-bit processor core and owns its current status word. Every clock cycle it looks at seven exception request lines: reset, undefined instruction, software interrupt, instruction prefetch abort, data abort, normal interrupt and fast interrupt. It drops any interrupt whose mask bit is set and keeps the most urgent of the remaining requests. It then performs the whole entry in one clock edge.

The entry does the following at that one edge. The old status word goes into a saved-status bank, and the entry of that bank is picked by the new mode. The mode field and the mask bits are rewritten. The instruction-set state flag is cleared, which selects the 32-bit state. The return address goes out to the core on a link-register write port. The program counter is redirected to a fixed vector.

A one-cycle redirect pulse tells the core to flush its pipeline. When no exception is taken, the core can overwrite the status word through a write port. The saved status of the current mode is always visible at an output, for use on exception return.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset `rst`, `cur_status` is 0x000000D3: mode 10011 (svc) in bits [4:0], I (bit 7) = 1, F (bit 6) = 1, T (bit 5) = 0, flags [31:28] = 0. In the same state `redirect` and `lr_we` are 0.
- R2: The vector depends on the winning source. Reset gives 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. The value 0x14 never appears on `redirect_pc`.
- R3: Among the requests that are not masked, the winner is chosen in this order: reset, data abort, FIQ, IRQ, prefetch abort, software interrupt, undefined instruction. If software interrupt and undefined instruction are asserted together, software interrupt wins.
- R4: An IRQ request is taken only while status bit 7 (I) is 0, and an FIQ request only while bit 6 (F) is 0. A masked request alone gives no redirect and leaves `cur_status` unchanged.
- R5: Each source sets its own new mode. Reset and software interrupt give svc 10011, both aborts give abt 10111, undefined gives und 11011, IRQ gives irq 10010 and FIQ gives fiq 10001.
- R6: Reset and FIQ entry set both I and F. Every other entry sets I and leaves F unchanged.
- R7: Every entry clears T (bit 5).
- R8: On every entry except reset, `lr_we` pulses together with `redirect`. In that cycle `lr_mode` is the new mode and `lr_data` is the sampled `cur_pc` + 4. Reset entry leaves `lr_we` at 0.
- R9: On every entry except reset, the status word from just before entry is stored for the new mode, and it appears on `saved_status` while the core is in that mode. Reset entry does not change any stored value.
- R10: `redirect` goes high in the cycle after a request is sampled. A single-cycle request gives a redirect pulse of exactly one cycle.
- R11: When `st_we` is high and no exception is taken, `cur_status` takes `st_wdata` on the next cycle. If an exception is taken in the same cycle, the exception entry wins and the write is dropped.
- R12: Entry keeps the condition flags [31:28] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_pc | input | AW | Core program counter used to form the return address |
| st_we | input | 1 | Status write enable |
| st_wdata | input | 32 | Status write value |
| redirect | output | 1 | One-cycle pipeline flush and PC load pulse |
| redirect_pc | output | AW | Vector address |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | AW | Return address |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode (0 in usr/sys) |

## Verification
All 128 combinations of the seven request lines are applied under each of the four I/F mask settings. Each case starts from a user-mode status word with T set and a different flag pattern. This separates the priority order, the effect of each mask and the per-source choice of mode, mask and vector. It also shows that flags are kept and that T is cleared. The cases where software interrupt and undefined are asserted together, or where an interrupt is asserted while masked, show the tie rule and the masking. Directed sequences cover the collision between a status write and an entry, and show that reset entry leaves the saved status untouched.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int SW       = 32;
  localparam int NSRC     = 7;
  localparam int SRC_IW   = $clog2(NSRC);
  localparam int BANK_AW  = 3;
  localparam int BANKS    = 1 << BANK_AW;
  localparam int VEC_W    = 8;

  localparam int ST_I = 7;
  localparam int ST_F = 6;
  localparam int ST_T = 5;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [SW-1:0] ST_RESET = 32'h0000_00D3;

  // Priority index order: lower index wins
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_DABT = 3'd2,
    SRC_FIQ  = 3'd3,
    SRC_IRQ  = 3'd4,
    SRC_PABT = 3'd5,
    SRC_SWI  = 3'd6,
    SRC_UND  = 3'd7
  } exc_src_e;

  function automatic logic [VEC_W-1:0] vec_of(exc_src_e s);
    case (s)
      SRC_RST:  vec_of = 8'h00;
      SRC_UND:  vec_of = 8'h04;
      SRC_SWI:  vec_of = 8'h08;
      SRC_PABT: vec_of = 8'h0C;
      SRC_DABT: vec_of = 8'h10;
      SRC_IRQ:  vec_of = 8'h18;
      SRC_FIQ:  vec_of = 8'h1C;
      default:  vec_of = 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(exc_src_e s);
    case (s)
      SRC_RST, SRC_SWI:   mode_of = M_SVC;
      SRC_DABT, SRC_PABT: mode_of = M_ABT;
      SRC_UND:            mode_of = M_UND;
      SRC_IRQ:            mode_of = M_IRQ;
      SRC_FIQ:            mode_of = M_FIQ;
      default:            mode_of = M_SVC;
    endcase
  endfunction

  function automatic logic [BANK_AW-1:0] bank_of(logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd1;
      M_IRQ:   bank_of = 3'd2;
      M_SVC:   bank_of = 3'd3;
      M_ABT:   bank_of = 3'd4;
      M_UND:   bank_of = 3'd5;
      default: bank_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N  = 7,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Scan from lowest priority upward so the lowest set index is kept
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int DW    = 32,
  parameter int AWID  = 3,
  parameter int DEPTH = 1 << AWID
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AWID-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AWID-1:0] raddr,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] RVAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] take_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= RVAL;
    else if (take)  q <= take_val;
    else if (wr_en) q <= wr_val;
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int RET_OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_rst,
  input  logic          req_und,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic [AW-1:0] cur_pc,
  input  logic          st_we,
  input  logic [31:0]   st_wdata,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          lr_we,
  output logic [4:0]    lr_mode,
  output logic [AW-1:0] lr_data,
  output logic [31:0]   cur_status,
  output logic [31:0]   saved_status
);

  logic [NSRC-1:0]   req_vec;
  logic              take;
  logic [SRC_IW-1:0] win_idx;
  exc_src_e          win_src;
  logic [4:0]        new_mode;
  logic [SW-1:0]     entry_status;
  logic              set_f;
  logic [SW-1:0]     bank_rd;
  logic [BANK_AW-1:0] rd_bank;

  // Masking, then priority ordering (index 0 = highest)
  always_comb begin
    req_vec[0] = req_rst;
    req_vec[1] = req_dabt;
    req_vec[2] = req_fiq & ~cur_status[ST_F];
    req_vec[3] = req_irq & ~cur_status[ST_I];
    req_vec[4] = req_pabt;
    req_vec[5] = req_swi;
    req_vec[6] = req_und;
  end

  exc_arbiter #(.N(NSRC), .IW(SRC_IW)) u_arb (
    .req (req_vec),
    .any (take),
    .idx (win_idx)
  );

  assign win_src  = take ? exc_src_e'(win_idx + SRC_IW'(1)) : SRC_NONE;
  assign new_mode = mode_of(win_src);
  assign set_f    = (win_src == SRC_FIQ) || (win_src == SRC_RST);

  always_comb begin
    entry_status        = cur_status;
    entry_status[4:0]   = new_mode;
    entry_status[ST_T]  = 1'b0;
    entry_status[ST_I]  = 1'b1;
    entry_status[ST_F]  = cur_status[ST_F] | set_f;
  end

  exc_status_reg #(.DW(SW), .RVAL(ST_RESET)) u_st (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_val (entry_status),
    .wr_en    (st_we),
    .wr_val   (st_wdata),
    .q        (cur_status)
  );

  assign rd_bank = bank_of(cur_status[4:0]);

  exc_bank #(.DW(SW), .AWID(BANK_AW), .DEPTH(BANKS)) u_bank (
    .clk   (clk),
    .we    (take && (win_src != SRC_RST)),
    .waddr (bank_of(new_mode)),
    .wdata (cur_status),
    .raddr (rd_bank),
    .rdata (bank_rd)
  );

  assign saved_status = (rd_bank == '0) ? '0 : bank_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      lr_we       <= 1'b0;
      redirect_pc <= '0;
      lr_mode     <= M_SVC;
      lr_data     <= '0;
    end else begin
      redirect <= take;
      lr_we    <= take && (win_src != SRC_RST);
      if (take) begin
        redirect_pc <= {{(AW-VEC_W){1'b0}}, vec_of(win_src)};
        lr_mode     <= new_mode;
        lr_data     <= cur_pc + AW'(RET_OFS);
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_sva.sv
module exc_entry_ctrl_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_rst,
  input logic          req_und,
  input logic          req_swi,
  input logic          req_pabt,
  input logic          req_dabt,
  input logic          req_irq,
  input logic          req_fiq,
  input logic [AW-1:0] cur_pc,
  input logic          redirect,
  input logic [AW-1:0] redirect_pc,
  input logic          lr_we,
  input logic [4:0]    lr_mode,
  input logic [AW-1:0] lr_data,
  input logic [31:0]   cur_status
);

  logic only_irq, only_fiq;
  assign only_irq = req_irq && !req_rst && !req_und && !req_swi && !req_pabt && !req_dabt && !req_fiq;
  assign only_fiq = req_fiq && !req_rst && !req_und && !req_swi && !req_pabt && !req_dabt && !req_irq;

  p_no_reserved_vec_r2: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc != AW'(32'h14)) && (redirect_pc[1:0] == 2'b00));

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_status[7] && only_irq) |=> !redirect);

  p_fiq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_status[6] && only_fiq) |=> !redirect);

  p_fiq_entry_masks_r6: assert property (@(posedge clk) disable iff (rst)
    (redirect && redirect_pc == AW'(32'h1C)) |-> (cur_status[7] && cur_status[6] && cur_status[4:0] == 5'b10001));

  p_t_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !cur_status[5]);

  p_link_value_r8: assert property (@(posedge clk) disable iff (rst)
    (redirect && redirect_pc != '0) |-> (lr_we && lr_data == $past(cur_pc) + AW'(4) && lr_mode == cur_status[4:0]));

  p_no_link_on_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (redirect && redirect_pc == '0) |-> !lr_we);

  p_lr_with_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> redirect);

  p_flags_kept_r12: assert property (@(posedge clk) disable iff (rst)
    redirect |-> cur_status[31:28] == $past(cur_status[31:28]));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_sva #(.AW(AW)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_rst     (req_rst),
  .req_und     (req_und),
  .req_swi     (req_swi),
  .req_pabt    (req_pabt),
  .req_dabt    (req_dabt),
  .req_irq     (req_irq),
  .req_fiq     (req_fiq),
  .cur_pc      (cur_pc),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .lr_we       (lr_we),
  .lr_mode     (lr_mode),
  .lr_data     (lr_data),
  .cur_status  (cur_status)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
  logic [AW-1:0] cur_pc;
  logic          st_we;
  logic [31:0]   st_wdata;
  logic          redirect;
  logic [AW-1:0] redirect_pc;
  logic          lr_we;
  logic [4:0]    lr_mode;
  logic [AW-1:0] lr_data;
  logic [31:0]   cur_status;
  logic [31:0]   saved_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.AW(AW), .RET_OFS(4)) u_exc_entry_ctrl (
    .clk, .rst, .req_rst, .req_und, .req_swi, .req_pabt, .req_dabt,
    .req_irq, .req_fiq, .cur_pc, .st_we, .st_wdata, .redirect,
    .redirect_pc, .lr_we, .lr_mode, .lr_data, .cur_status, .saved_status
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_reqs(logic [6:0] r);
    // bit0 rst, 1 und, 2 swi, 3 pabt, 4 dabt, 5 irq, 6 fiq
    req_rst  = r[0]; req_und = r[1]; req_swi = r[2]; req_pabt = r[3];
    req_dabt = r[4]; req_irq = r[5]; req_fiq = r[6];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] s1;
    rst = 1'b1; set_reqs(7'd0); cur_pc = '0; st_we = 1'b0; st_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", cur_status, 32'h0000_00D3);
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    chk("R1 lr_we", {31'd0, lr_we}, 32'd0);

    // Exhaustive sweep: masks x request combos
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        logic bi, bf, tk;
        logic [31:0] s, exp_st;
        logic [7:0]  vec;
        logic [4:0]  md;
        logic        setf, isrst;
        logic [3:0]  fl;
        logic [AW-1:0] pc;
        bi = m[1]; bf = m[0];
        fl = 4'(r + m * 5);
        s  = {fl, 20'd0, bi, bf, 1'b1, 5'b10000};
        pc = 32'h0000_1000 + 32'(r * 8 + m * 1024);

        @(negedge clk);
        set_reqs(7'd0); st_we = 1'b1; st_wdata = s;
        @(negedge clk);
        st_we = 1'b0;
        chk("R11 write", cur_status, s);
        set_reqs(7'(r)); cur_pc = pc;
        @(negedge clk);
        set_reqs(7'd0);

        tk = 1'b1; setf = 1'b0; isrst = 1'b0; vec = 8'h00; md = 5'b10011;
        if (r[0])             begin vec = 8'h00; md = 5'b10011; setf = 1'b1; isrst = 1'b1; end
        else if (r[4])        begin vec = 8'h10; md = 5'b10111; end
        else if (r[6] && !bf) begin vec = 8'h1C; md = 5'b10001; setf = 1'b1; end
        else if (r[5] && !bi) begin vec = 8'h18; md = 5'b10010; end
        else if (r[3])        begin vec = 8'h0C; md = 5'b10111; end
        else if (r[2])        begin vec = 8'h08; md = 5'b10011; end
        else if (r[1])        begin vec = 8'h04; md = 5'b11011; end
        else tk = 1'b0;

        chk("R3/R4 redirect", {31'd0, redirect}, {31'd0, tk});
        if (tk) begin
          exp_st = {fl, 20'd0, 1'b1, bf | setf, 1'b0, md};
          chk("R2/R3 vector", redirect_pc, {24'd0, vec});
          chk("R5/R6/R7/R12 status", cur_status, exp_st);
          chk("R8 lr_we", {31'd0, lr_we}, {31'd0, !isrst});
          if (!isrst) begin
            chk("R8 lr_mode", {27'd0, lr_mode}, {27'd0, md});
            chk("R8 lr_data", lr_data, pc + 32'd4);
          end
        end else begin
          chk("R4 status kept", cur_status, s);
        end
        @(negedge clk);
        chk("R10 pulse", {31'd0, redirect}, 32'd0);
        if (tk && !isrst) chk("R9 saved", saved_status, s);
      end
    end

    // R11 collision: write and software interrupt in same cycle
    s1 = 32'h5000_0030;
    @(negedge clk);
    st_we = 1'b1; st_wdata = s1;
    @(negedge clk);
    st_we = 1'b1; st_wdata = 32'hA000_0010; set_reqs(7'b0000100); cur_pc = 32'h200;
    @(negedge clk);
    st_we = 1'b0; set_reqs(7'd0);
    chk("R11 entry wins", cur_status, 32'h5000_0093);
    chk("R9 svc saved", saved_status, s1);

    // R9 reset entry leaves saved value alone
    @(negedge clk);
    st_we = 1'b1; st_wdata = 32'h3000_00F0;
    @(negedge clk);
    st_we = 1'b0; set_reqs(7'b0000001);
    @(negedge clk);
    set_reqs(7'd0);
    chk("R2 reset vector", redirect_pc, 32'h0);
    chk("R6 reset status", cur_status, 32'h3000_00D3);
    chk("R9 reset no save", saved_status, s1);

    // R1 again after a synchronous reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 status again", cur_status, 32'h0000_00D3);

    finish_run();
  end

endmodule